// File: doc/BRIEF.md
# Program Memory Write Unlock Sequencer

This block guards self-programming of on-chip program memory. Software reaches it over a byte-wide register bus with single-cycle writes and combinational reads. The block holds a control register, a three-byte pointer that addresses program memory, and a key register that stores nothing. A program or erase operation starts only after software writes two fixed key bytes in order to the key register and then sets the go bit in the control register. Write-enable must already be set in the control register before that write.

When an operation starts, the block sends a one-cycle start strobe to the memory controller, together with the latched target-space select, the erase/program select and the pointer. It stalls the processor until the controller reports completion. If a master-clear or watchdog reset arrives while an operation is running, the block sets a sticky error flag that survives that reset, so software can detect the interrupted write and retry it. Only a power-on reset clears this flag.

Register map (bus_addr): 0 control, 1 key, 2 pointer bits 7:0, 3 pointer bits 15:8, 4 pointer bits 21:16. Control bits: 0 go, 1 write-enable, 2 error, 3 erase select, 4 configuration-space select.

Top module: `nvm_write_guard`

## Requirements
- R1: After power-on reset (`rst`), the control and pointer registers read 0, `cpu_stall` and `mem_start` are 0, and `mem_addr` is 0.
- R2: The sequence key write 0x55, key write 0xAA, then a control write with go (bit 0) = 1 while write-enable (bit 1) is already 1 raises `mem_start` for exactly one cycle, in the cycle after the control write. `cpu_stall` rises in the same cycle.
- R3: Go is ignored if the keys come in the wrong order, if a second key is wrong, or if any bus read or write to another register falls between the two keys.
- R4: Go is ignored when write-enable is set by the same control write rather than beforehand.
- R5: The unlock is used up by any register write after the second key, so each start needs a new key pair. Reads after the second key do not use it up.
- R6: A read of the key register returns 0x00.
- R7: The erase select (bit 3) and configuration select (bit 4) of the starting write drive `mem_erase` and `mem_cfg_sel`. Control writes during an operation do not change them, and control writes while idle update them.
- R8: While busy, go reads 1 and a software write of go = 0 does not clear it. `mem_done` clears busy and `cpu_stall` in the following cycle, and `mem_done` while idle has no effect.
- R9: A master-clear (`rst_mclr`) or watchdog (`rst_wdt`) reset during an operation ends it and sets the error bit (bit 2). Either reset clears write-enable, the selects and the pointer, and leaves the error bit unchanged.
- R10: Writing 1 to the error bit clears it, writing 0 leaves it unchanged, and power-on reset clears it.
- R11: `mem_addr` is the 22-bit pointer built from the three pointer registers. The upper register keeps 6 bits and reads 0 in bits 7:6. Pointer writes during an operation are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| rst_mclr | input | 1 | Master-clear reset, synchronous, active high |
| rst_wdt | input | 1 | Watchdog reset, synchronous, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when no read |
| mem_done | input | 1 | Completion from the memory controller |
| mem_start | output | 1 | One-cycle operation start strobe |
| mem_erase | output | 1 | 1 selects erase, 0 selects program |
| mem_cfg_sel | output | 1 | 1 targets configuration space, 0 targets program memory |
| mem_addr | output | 22 | Program memory pointer |
| cpu_stall | output | 1 | Processor stall while an operation runs |

## Verification
Register read data is combinational, so the bench samples it in the same cycle as the read strobe, before the next edge. Every other result (the start strobe, stall, latched selects, pointer and error bit) comes from a register that loads on the edge that takes the write, the completion or the reset. The bench therefore checks these at the falling edge right after that rising edge. The one-cycle width of `mem_start` is checked one falling edge later. Cases that must have no effect are checked through `mem_start`, `cpu_stall` and a control read-back once the stimulus has been taken.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;

    localparam int BUS_W  = 8;
    localparam int REG_AW = 3;

    localparam logic [BUS_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [BUS_W-1:0] KEY_SECOND = 8'hAA;

    typedef enum logic [REG_AW-1:0] {
        REG_CTRL    = 3'd0,
        REG_KEY     = 3'd1,
        REG_PTR_LO  = 3'd2,
        REG_PTR_MID = 3'd3,
        REG_PTR_UP  = 3'd4
    } reg_sel_e;

    localparam int CTRL_FIELDS_W = 5;

    // packed order sets bit positions: go=0, wen=1, err=2, erase=3, cfg=4
    typedef struct packed {
        logic cfg;
        logic erase;
        logic err;
        logic wen;
        logic go;
    } ctrl_fields_t;

    typedef struct packed {
        logic cfg;
        logic erase;
    } op_sel_t;

    typedef struct packed {
        logic                    wr;
        logic                    rd;
        logic [REG_AW-1:0]       addr;
        logic [BUS_W-1:0]        wdata;
    } bus_req_t;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_HALF  = 2'd1,
        UL_ARMED = 2'd2
    } unlock_st_e;

    function automatic logic ptr_sel_hit(input logic [REG_AW-1:0] a, input int idx);
        return a == REG_AW'(int'(REG_PTR_LO) + idx);
    endfunction

endpackage

// File: rtl/nvm_key_fsm.sv
module nvm_key_fsm
    import nvm_guard_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     soft_rst,
    input  bus_req_t req,
    output logic     armed
);
    unlock_st_e st_q, st_d;
    logic       key_wr;
    logic       any_acc;

    assign key_wr  = req.wr && (req.addr == REG_KEY);
    assign any_acc = req.wr || req.rd;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            UL_IDLE: begin
                if (key_wr && req.wdata == KEY_FIRST) st_d = UL_HALF;
            end
            UL_HALF: begin
                if (key_wr && req.wdata == KEY_SECOND) st_d = UL_ARMED;
                else if (any_acc)                      st_d = UL_IDLE;
            end
            UL_ARMED: begin
                if (key_wr)      st_d = (req.wdata == KEY_FIRST) ? UL_HALF : UL_IDLE;
                else if (req.wr) st_d = UL_IDLE;
            end
            default: st_d = UL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) st_q <= UL_IDLE;
        else                 st_q <= st_d;
    end

    assign armed = (st_q == UL_ARMED);

    // R3: arming only ever follows a correct second key
    assert_arm_after_key_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(req.wr && req.addr == REG_KEY && req.wdata == KEY_SECOND));

    // R5: a non-key register write while armed uses up the unlock
    assert_arm_consumed_R5: assert property (@(posedge clk) disable iff (rst)
        (armed && req.wr && req.addr != REG_KEY) |=> !armed);

endmodule

// File: rtl/nvm_ptr_regs.sv
module nvm_ptr_regs
    import nvm_guard_pkg::*;
#(
    parameter int PTR_W = 22
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          soft_rst,
    input  logic                          wr,
    input  logic [REG_AW-1:0]             addr,
    input  logic [BUS_W-1:0]              wdata,
    input  logic                          lock,
    output logic [PTR_W-1:0]              ptr,
    output logic [(PTR_W+BUS_W-1)/BUS_W-1:0][BUS_W-1:0] byte_rd
);
    localparam int NBYTES = (PTR_W + BUS_W - 1) / BUS_W;

    logic [PTR_W-1:0] ptr_q;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        localparam int BW = ((PTR_W - BUS_W*i) >= BUS_W) ? BUS_W : (PTR_W - BUS_W*i);
        logic [BW-1:0] q;
        logic          hit;

        assign hit = wr && !lock && ptr_sel_hit(addr, i);

        always_ff @(posedge clk) begin
            if (rst || soft_rst) q <= '0;
            else if (hit)        q <= wdata[BW-1:0];
        end

        assign ptr_q[BUS_W*i +: BW] = q;
        assign byte_rd[i]           = BUS_W'(q);
    end

    assign ptr = ptr_q;

    // R11: pointer stays put while an operation runs
    assert_ptr_locked_R11: assert property (@(posedge clk) disable iff (rst)
        (lock && !soft_rst) |=> $stable(ptr));

endmodule

// File: rtl/nvm_ctl_core.sv
module nvm_ctl_core
    import nvm_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         soft_rst,
    input  logic         ctrl_wr,
    input  ctrl_fields_t ctrl_in,
    input  logic         armed,
    input  logic         mem_done,
    output logic         busy,
    output logic         wen,
    output logic         err,
    output op_sel_t      op,
    output logic         mem_start
);
    logic    busy_q, wen_q, err_q, start_q;
    op_sel_t op_q;
    logic    launch;

    assign launch = ctrl_wr && armed && ctrl_in.go && wen_q && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            wen_q   <= 1'b0;
            err_q   <= 1'b0;
            start_q <= 1'b0;
            op_q    <= '0;
        end else if (soft_rst) begin
            busy_q  <= 1'b0;
            wen_q   <= 1'b0;
            err_q   <= err_q | busy_q;
            start_q <= 1'b0;
            op_q    <= '0;
        end else begin
            start_q <= launch;
            if (launch)                busy_q <= 1'b1;
            else if (busy_q && mem_done) busy_q <= 1'b0;
            if (ctrl_wr) begin
                wen_q <= ctrl_in.wen;
                if (!busy_q) op_q <= '{cfg: ctrl_in.cfg, erase: ctrl_in.erase};
                if (ctrl_in.err) err_q <= 1'b0;
            end
        end
    end

    assign busy      = busy_q;
    assign wen       = wen_q;
    assign err       = err_q;
    assign op        = op_q;
    assign mem_start = start_q;

    // R2: strobe comes with busy and lasts a single cycle
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        mem_start |-> busy);
    assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
        mem_start |=> !mem_start);

    // R4: a start needs write-enable set in the cycle of the go write
    assert_start_wen_R4: assert property (@(posedge clk) disable iff (rst)
        mem_start |-> $past(wen));

    // R7: selects frozen during an operation
    assert_op_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !soft_rst) |=> $stable(op));

    // R8: busy holds until completion, completion clears it
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_done && !soft_rst) |=> busy);
    assert_busy_done_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_done && !soft_rst) |=> !busy);

    // R9: an interrupting reset leaves the error flag set
    assert_err_on_abort_R9: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && busy) |=> err);

endmodule

// File: rtl/nvm_write_guard.sv
module nvm_write_guard
    import nvm_guard_pkg::*;
#(
    parameter int PTR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_mclr,
    input  logic              rst_wdt,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              mem_done,
    output logic              mem_start,
    output logic              mem_erase,
    output logic              mem_cfg_sel,
    output logic [PTR_W-1:0]  mem_addr,
    output logic              cpu_stall
);
    localparam int NBYTES = (PTR_W + BUS_W - 1) / BUS_W;

    bus_req_t     req;
    logic         soft_rst;
    logic         armed;
    logic         ctrl_wr;
    ctrl_fields_t ctrl_in;
    ctrl_fields_t ctrl_rd;
    logic         busy, wen, err;
    op_sel_t      op;
    logic [NBYTES-1:0][BUS_W-1:0] ptr_bytes;

    assign req      = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, wdata: bus_wdata};
    assign soft_rst = rst_mclr | rst_wdt;
    assign ctrl_wr  = bus_wr && (bus_addr == REG_CTRL);
    assign ctrl_in  = ctrl_fields_t'(bus_wdata[CTRL_FIELDS_W-1:0]);

    nvm_key_fsm u_keys (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .req      (req),
        .armed    (armed)
    );

    nvm_ctl_core u_ctl (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .ctrl_wr   (ctrl_wr),
        .ctrl_in   (ctrl_in),
        .armed     (armed),
        .mem_done  (mem_done),
        .busy      (busy),
        .wen       (wen),
        .err       (err),
        .op        (op),
        .mem_start (mem_start)
    );

    nvm_ptr_regs #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .lock     (busy),
        .ptr      (mem_addr),
        .byte_rd  (ptr_bytes)
    );

    assign ctrl_rd = '{cfg: op.cfg, erase: op.erase, err: err, wen: wen, go: busy};

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == REG_CTRL) bus_rdata = BUS_W'(ctrl_rd);
            for (int i = 0; i < NBYTES; i++) begin
                if (ptr_sel_hit(bus_addr, i)) bus_rdata = ptr_bytes[i];
            end
        end
    end

    assign mem_erase   = op.erase;
    assign mem_cfg_sel = op.cfg;
    assign cpu_stall   = busy;

    // R6: key register holds nothing
    assert_key_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == REG_KEY) |-> bus_rdata == '0);

    // R8: stall follows a start
    assert_stall_after_start_R8: assert property (@(posedge clk) disable iff (rst)
        mem_start |-> cpu_stall);

endmodule

// File: tb/tb_nvm_write_guard.sv
module tb_nvm_write_guard;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1, rst_mclr = 1'b0, rst_wdt = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        mem_done = 1'b0;
    logic        mem_start, mem_erase, mem_cfg_sel, cpu_stall;
    logic [21:0] mem_addr;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_write_guard dut (
        .clk(clk), .rst(rst), .rst_mclr(rst_mclr), .rst_wdt(rst_wdt),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_done(mem_done),
        .mem_start(mem_start), .mem_erase(mem_erase), .mem_cfg_sel(mem_cfg_sel),
        .mem_addr(mem_addr), .cpu_stall(cpu_stall)
    );

    localparam logic [2:0] A_CTRL = 3'd0, A_KEY = 3'd1, A_LO = 3'd2, A_MID = 3'd3, A_UP = 3'd4;
    localparam logic [7:0] GO = 8'h01, WEN = 8'h02, ERR = 8'h04, ERS = 8'h08, CFG = 8'h10;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic unlock();
        bwr(A_KEY, 8'h55);
        bwr(A_KEY, 8'hAA);
    endtask

    task automatic pulse_done();
        @(negedge clk); mem_done = 1'b1;
        @(negedge clk); mem_done = 1'b0;
    endtask

    task automatic pulse_reset(input int kind);
        @(negedge clk);
        if (kind == 0) rst = 1'b1; else if (kind == 1) rst_mclr = 1'b1; else rst_wdt = 1'b1;
        @(negedge clk); rst = 1'b0; rst_mclr = 1'b0; rst_wdt = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        brd(A_CTRL, d); chk("R1 ctrl after reset", d, 0);
        brd(A_LO, d);   chk("R1 ptr lo after reset", d, 0);
        brd(A_UP, d);   chk("R1 ptr up after reset", d, 0);
        chk("R1 stall", cpu_stall, 0);
        chk("R1 start", mem_start, 0);
        chk("R1 addr", mem_addr, 0);
    endtask

    task automatic t_basic();
        logic [7:0] d;
        bwr(A_CTRL, WEN);
        unlock();
        bwr(A_CTRL, WEN | GO);
        chk("R2 start strobe", mem_start, 1);
        chk("R2 stall with start", cpu_stall, 1);
        @(negedge clk);
        chk("R2 strobe one cycle", mem_start, 0);
        brd(A_CTRL, d); chk("R8 go reads 1 while busy", d, WEN | GO);
        bwr(A_CTRL, WEN);
        brd(A_CTRL, d); chk("R8 go not cleared by software", d, WEN | GO);
        chk("R8 stall held", cpu_stall, 1);
        pulse_done();
        chk("R8 stall cleared by done", cpu_stall, 0);
        brd(A_CTRL, d); chk("R8 go cleared by done", d, WEN);
        pulse_done();
        chk("R8 done while idle", cpu_stall, 0);
    endtask

    task automatic t_bad_keys();
        logic [7:0] d;
        bwr(A_CTRL, WEN);
        bwr(A_KEY, 8'hAA); bwr(A_KEY, 8'h55); bwr(A_CTRL, WEN | GO);
        chk("R3 reversed keys start", mem_start, 0);
        chk("R3 reversed keys stall", cpu_stall, 0);
        bwr(A_KEY, 8'h55); bwr(A_KEY, 8'hAB); bwr(A_CTRL, WEN | GO);
        chk("R3 wrong second key", cpu_stall, 0);
        bwr(A_KEY, 8'h55); brd(A_CTRL, d); bwr(A_KEY, 8'hAA); bwr(A_CTRL, WEN | GO);
        chk("R3 read between keys", cpu_stall, 0);
        bwr(A_KEY, 8'h55); bwr(A_LO, 8'h00); bwr(A_KEY, 8'hAA); bwr(A_CTRL, WEN | GO);
        chk("R3 write between keys", cpu_stall, 0);
        brd(A_CTRL, d); chk("R3 go reads 0", d, WEN);
    endtask

    task automatic t_wen_and_reuse();
        logic [7:0] d;
        bwr(A_CTRL, 8'h00);
        unlock();
        bwr(A_CTRL, WEN | GO);
        chk("R4 wen with go same write", cpu_stall, 0);
        bwr(A_CTRL, WEN | GO);
        chk("R5 go without new keys", cpu_stall, 0);
        unlock(); bwr(A_MID, 8'h00); bwr(A_CTRL, WEN | GO);
        chk("R5 other write consumes unlock", cpu_stall, 0);
        unlock(); brd(A_CTRL, d); bwr(A_CTRL, WEN | GO);
        chk("R5 read keeps unlock", mem_start, 1);
        pulse_done();
        bwr(A_CTRL, WEN | GO);
        chk("R5 second go needs keys", cpu_stall, 0);
    endtask

    task automatic t_key_read();
        logic [7:0] d;
        bwr(A_KEY, 8'h55);
        brd(A_KEY, d); chk("R6 key reads zero", d, 0);
    endtask

    task automatic t_target();
        logic [7:0] d;
        bwr(A_LO, 8'h34); bwr(A_MID, 8'h12); bwr(A_UP, 8'hFF);
        chk("R11 pointer assembled", mem_addr, 22'h3F1234);
        brd(A_UP, d); chk("R11 upper keeps 6 bits", d, 8'h3F);
        bwr(A_CTRL, WEN);
        unlock();
        bwr(A_CTRL, CFG | ERS | WEN | GO);
        chk("R7 cfg select", mem_cfg_sel, 1);
        chk("R7 erase select", mem_erase, 1);
        bwr(A_CTRL, WEN);
        chk("R7 cfg frozen", mem_cfg_sel, 1);
        brd(A_CTRL, d); chk("R7 ctrl during busy", d, CFG | ERS | WEN | GO);
        bwr(A_LO, 8'h00);
        chk("R11 pointer write ignored while busy", mem_addr, 22'h3F1234);
        pulse_done();
        bwr(A_CTRL, WEN);
        chk("R7 cfg updates when idle", mem_cfg_sel, 0);
        chk("R7 erase updates when idle", mem_erase, 0);
    endtask

    task automatic t_err();
        logic [7:0] d;
        bwr(A_LO, 8'h77);
        unlock();
        bwr(A_CTRL, WEN | GO);
        chk("R2 start before abort", cpu_stall, 1);
        pulse_reset(1);
        chk("R9 mclr ends op", cpu_stall, 0);
        brd(A_CTRL, d); chk("R9 err set wen cleared", d, ERR);
        chk("R9 pointer cleared", mem_addr, 0);
        pulse_reset(1);
        brd(A_CTRL, d); chk("R9 err survives idle mclr", d, ERR);
        bwr(A_CTRL, WEN);
        brd(A_CTRL, d); chk("R10 write 0 keeps err", d, ERR | WEN);
        bwr(A_CTRL, WEN | ERR);
        brd(A_CTRL, d); chk("R10 write 1 clears err", d, WEN);
        unlock();
        bwr(A_CTRL, WEN | GO);
        pulse_reset(2);
        brd(A_CTRL, d); chk("R9 wdt abort sets err", d, ERR);
        pulse_reset(0);
        brd(A_CTRL, d); chk("R10 power-on clears err", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_bad_keys();
        t_wen_and_reuse();
        t_key_read();
        t_target();
        t_err();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule